// File: doc/BRIEF.md
# Indirect PHY Register Access Bridge

This block sits on a host controller's register bus and lets software reach a small PHY register file through two words of the host map. One is a command word, which holds the PHY register offset, a direction bit and a read-only busy flag. The other is a data word, which holds the byte to be written or the byte that came back. Writing the command word starts exactly one PHY transaction. Software then polls the busy flag until it drops.

The PHY side is a plain register port. It carries an offset, a write byte, a read byte and a request/acknowledge pair. The request is held high, together with a steady offset, direction and write byte, until the PHY acknowledges. The acknowledge cycle ends the transaction. On a read, the same cycle also loads the returned byte into the data word.

For a PHY write, software loads the data word and then writes the command word with the direction bit set. For a PHY read, software clears the data word and then writes the command word with the direction bit clear. Accesses to other host offsets leave the block untouched and report a miss, so the host can route them elsewhere.

Top module: `phy_ind_bridge`

## Requirements
- R1: After reset, busy reads 0, phy_req is 0, and both the command word and the data word read 0.
- R2: A command-word write (host offset 0x300) while idle makes phy_req 1 from the next cycle on. In that cycle phy_addr equals the written bits [7:0], and phy_we equals the written bit 8 (1 = PHY write, 0 = PHY read).
- R3: On a PHY write, phy_wdata carries the low byte of the data word as it stood at launch. phy_addr, phy_we and phy_wdata stay unchanged while the request waits for acknowledge.
- R4: On a PHY read, the acknowledge cycle loads phy_rdata into data-word bits [7:0]. Busy (command-word bit 9) reads 0 in the cycle after the acknowledge.
- R5: Busy reads 1 from the cycle after a launch until the acknowledge.
- R6: A command-word write while busy is 1 is ignored. The PHY port outputs keep their values, and the stored offset and direction do not change.
- R7: The data word (host offset 0x304) stores only its bits [7:0]. Its bits [31:8] and command-word bits [31:10] read 0.
- R8: A read of the command word returns the offset of the last accepted launch in bits [7:0] and its direction in bit 8.
- R9: A write or read at any other host offset changes no state and returns read data 0, with bus_hit 0. An access to either of the two words gives bus_hit 1.
- R10: An acknowledge while no transaction is in progress is ignored. The data word and busy do not change.
- R11: An acknowledge that ends a PHY write leaves the data word unchanged, whatever phy_rdata carries.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Host register write strobe |
| bus_rd | input | 1 | Host register read strobe |
| bus_addr | input | 12 | Host register byte offset |
| bus_wdata | input | 32 | Host write data |
| bus_rdata | output | 32 | Host read data |
| bus_hit | output | 1 | Access decodes to one of the two words |
| phy_req | output | 1 | PHY transaction request, held until acknowledge |
| phy_we | output | 1 | 1 = PHY write, 0 = PHY read |
| phy_addr | output | 8 | PHY register offset |
| phy_wdata | output | 8 | PHY write byte |
| phy_ack | input | 1 | PHY acknowledge, one cycle |
| phy_rdata | input | 8 | PHY read byte, valid with acknowledge |

## Verification
The bench builds the block with its default parameters: an 8-bit PHY offset, a 12-bit host offset, a 32-bit host word and combinational read-back. These defaults keep the whole PHY register space to 256 entries. The bench can therefore sweep every offset, first as a write and then as a read-back, through a PHY model whose acknowledge delay varies with the offset from zero to three cycles. Directed cases cover the acknowledge being held off by hand, so that the busy window, a command write arriving mid-transaction, a stray acknowledge and a misdirected host offset can each be inspected at the ports.

// File: rtl/phyb_pkg.sv
package phyb_pkg;
   typedef enum logic [1:0] {
      SEL_NONE = 2'd0,
      SEL_CMD  = 2'd1,
      SEL_DAT  = 2'd2
   } reg_sel_e;
endpackage

// File: rtl/phyb_decode.sv
module phyb_decode
   import phyb_pkg::*;
#(
   parameter int                BUS_AW  = 12,
   parameter logic [BUS_AW-1:0] CMD_OFS = 'h300,
   parameter logic [BUS_AW-1:0] DAT_OFS = 'h304
) (
   input  logic [BUS_AW-1:0] addr,
   output reg_sel_e          sel
);
   if (CMD_OFS == DAT_OFS) begin : g_bad_map
      $error("phyb_decode: command and data offsets collide");
   end

   always_comb begin
      if (addr == CMD_OFS)      sel = SEL_CMD;
      else if (addr == DAT_OFS) sel = SEL_DAT;
      else                      sel = SEL_NONE;
   end
endmodule

// File: rtl/phyb_engine.sv
module phyb_engine #(
   parameter int PHY_AW = 8,
   parameter int PHY_DW = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_wr,
   input  logic [PHY_AW-1:0] cmd_addr,
   input  logic              cmd_we,
   input  logic              dat_wr,
   input  logic [PHY_DW-1:0] dat_wbyte,
   output logic              busy,
   output logic [PHY_AW-1:0] last_addr,
   output logic              last_we,
   output logic [PHY_DW-1:0] dat_q,
   output logic              phy_req,
   output logic              phy_we,
   output logic [PHY_AW-1:0] phy_addr,
   output logic [PHY_DW-1:0] phy_wdata,
   input  logic              phy_ack,
   input  logic [PHY_DW-1:0] phy_rdata
);
   logic              busy_q, we_q;
   logic [PHY_AW-1:0] addr_q;
   logic [PHY_DW-1:0] wbyte_q, dat_r;
   logic              launch, done;

   assign launch = cmd_wr & ~busy_q;
   assign done   = busy_q & phy_ack;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         we_q    <= 1'b0;
         addr_q  <= '0;
         wbyte_q <= '0;
      end else if (launch) begin
         busy_q  <= 1'b1;
         we_q    <= cmd_we;
         addr_q  <= cmd_addr;
         wbyte_q <= dat_r;
      end else if (done) begin
         busy_q  <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              dat_r <= '0;
      else if (done && !we_q)  dat_r <= phy_rdata;
      else if (dat_wr)         dat_r <= dat_wbyte;
   end

   assign busy      = busy_q;
   assign last_addr = addr_q;
   assign last_we   = we_q;
   assign dat_q     = dat_r;
   assign phy_req   = busy_q;
   assign phy_we    = we_q;
   assign phy_addr  = addr_q;
   assign phy_wdata = wbyte_q;

   assert_launch_sets_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wr && !busy) |=> (busy && phy_req));
   assert_port_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (phy_req && !phy_ack) |=> (phy_req && $stable(phy_addr) && $stable(phy_we) && $stable(phy_wdata)));
   assert_busy_write_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && cmd_wr && !phy_ack) |=> ($stable(last_addr) && $stable(last_we)));
   assert_ack_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && phy_ack) |=> !busy);
   assert_stray_ack_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && phy_ack && !dat_wr && !cmd_wr) |=> ($stable(dat_q) && !busy));
   assert_write_ack_keeps_data_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && phy_we && phy_ack && !dat_wr) |=> $stable(dat_q));
endmodule

// File: rtl/phy_ind_bridge.sv
module phy_ind_bridge
   import phyb_pkg::*;
#(
   parameter int                BUS_AW  = 12,
   parameter int                BUS_DW  = 32,
   parameter int                PHY_AW  = 8,
   parameter int                PHY_DW  = 8,
   parameter logic [BUS_AW-1:0] CMD_OFS = 'h300,
   parameter logic [BUS_AW-1:0] DAT_OFS = 'h304,
   parameter bit                RD_REG  = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [BUS_AW-1:0] bus_addr,
   input  logic [BUS_DW-1:0] bus_wdata,
   output logic [BUS_DW-1:0] bus_rdata,
   output logic              bus_hit,
   output logic              phy_req,
   output logic              phy_we,
   output logic [PHY_AW-1:0] phy_addr,
   output logic [PHY_DW-1:0] phy_wdata,
   input  logic              phy_ack,
   input  logic [PHY_DW-1:0] phy_rdata
);
   localparam int WE_BIT   = PHY_AW;
   localparam int BUSY_BIT = PHY_AW + 1;

   if (BUSY_BIT >= BUS_DW) begin : g_bad_cmd
      $error("phy_ind_bridge: command fields exceed the bus word");
   end
   if (PHY_DW > BUS_DW) begin : g_bad_dat
      $error("phy_ind_bridge: PHY data wider than the bus word");
   end

   reg_sel_e          sel;
   logic              busy, last_we;
   logic [PHY_AW-1:0] last_addr;
   logic [PHY_DW-1:0] dat_q;
   logic [BUS_DW-1:0] cmd_word, dat_word, rd_mux;

   phyb_decode #(.BUS_AW(BUS_AW), .CMD_OFS(CMD_OFS), .DAT_OFS(DAT_OFS)) i_dec (
      .addr (bus_addr),
      .sel  (sel)
   );

   phyb_engine #(.PHY_AW(PHY_AW), .PHY_DW(PHY_DW)) i_eng (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_wr    (bus_wr && sel == SEL_CMD),
      .cmd_addr  (bus_wdata[PHY_AW-1:0]),
      .cmd_we    (bus_wdata[WE_BIT]),
      .dat_wr    (bus_wr && sel == SEL_DAT),
      .dat_wbyte (bus_wdata[PHY_DW-1:0]),
      .busy      (busy),
      .last_addr (last_addr),
      .last_we   (last_we),
      .dat_q     (dat_q),
      .phy_req   (phy_req),
      .phy_we    (phy_we),
      .phy_addr  (phy_addr),
      .phy_wdata (phy_wdata),
      .phy_ack   (phy_ack),
      .phy_rdata (phy_rdata)
   );

   always_comb begin
      cmd_word                = '0;
      cmd_word[PHY_AW-1:0]    = last_addr;
      cmd_word[WE_BIT]        = last_we;
      cmd_word[BUSY_BIT]      = busy;
      dat_word                = '0;
      dat_word[PHY_DW-1:0]    = dat_q;
      case (sel)
         SEL_CMD: rd_mux = cmd_word;
         SEL_DAT: rd_mux = dat_word;
         default: rd_mux = '0;
      endcase
   end

   assign bus_hit = (sel != SEL_NONE);

   if (RD_REG) begin : g_rd_flop
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      bus_rdata <= '0;
         else if (bus_rd) bus_rdata <= rd_mux;
      end
   end else begin : g_rd_comb
      assign bus_rdata = bus_rd ? rd_mux : '0;
   end
endmodule

// File: tb/test_phy_ind_bridge.sv
module test_phy_ind_bridge;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0, bus_rd = 1'b0;
   logic [11:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        bus_hit;
   logic        phy_req, phy_we;
   logic [7:0]  phy_addr, phy_wdata;
   logic        phy_ack = 1'b0;
   logic [7:0]  phy_rdata = '0;

   int total = 0, bad = 0;
   bit finished = 0;
   bit model_on = 0;
   bit started = 0;
   int cnt = 0;
   logic [7:0] mem [256];
   logic [7:0] exp_w;
   logic [31:0] rv;

   always #2 clk = ~clk;

   phy_ind_bridge i_phy_ind_bridge (.*);

   function automatic logic [7:0] pat(input int a);
      return 8'((a * 37 + 11) & 255);
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // PHY model: acknowledges after (offset mod 4) idle cycles
   always @(negedge clk) begin
      if (model_on) begin
         if (phy_ack) phy_ack = 1'b0;
         else if (phy_req) begin
            if (!started) begin started = 1; cnt = int'(phy_addr) % 4; end
            if (cnt == 0) begin
               if (phy_we) begin
                  chk("R3 phy_wdata at ack", {24'd0, phy_wdata}, {24'd0, exp_w});
                  mem[phy_addr] = phy_wdata;
               end else phy_rdata = mem[phy_addr];
               phy_ack = 1'b1;
               started = 0;
            end else cnt--;
         end
      end
   end

   task automatic bwr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 0;
   endtask

   task automatic brd(input logic [11:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_rd = 1; bus_addr = a;
      #1 d = bus_rdata;
      @(posedge clk);
      #1 bus_rd = 0;
   endtask

   task automatic poll();
      logic [31:0] v;
      for (int i = 0; i < 40; i++) begin
         brd(12'h300, v);
         if (!v[9]) return;
      end
      chk("R4 busy never cleared", 32'd1, 32'd0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 256; i++) mem[i] = 8'h00;
      repeat (3) @(negedge clk);
      // R1 reset state
      #1;
      chk("R1 phy_req", {31'd0, phy_req}, 32'd0);
      brd(12'h300, rv); chk("R1 cmd word", rv, 32'd0);
      brd(12'h304, rv); chk("R1 data word", rv, 32'd0);
      rst_n = 1'b1;
      brd(12'h300, rv); chk("R1 cmd word after release", rv, 32'd0);

      // R7 data word keeps only the low byte
      bwr(12'h304, 32'hDEADBEEF);
      brd(12'h304, rv); chk("R7 data width", rv, 32'h000000EF);

      // R9 other offsets
      bwr(12'h308, 32'hFFFFFFFF);
      bwr(12'h000, 32'h000003FF);
      @(negedge clk); bus_rd = 1; bus_addr = 12'h308; #1;
      chk("R9 miss hit", {31'd0, bus_hit}, 32'd0);
      chk("R9 miss rdata", bus_rdata, 32'd0);
      chk("R9 no launch", {31'd0, phy_req}, 32'd0);
      bus_addr = 12'h300; #1;
      chk("R9 cmd hit", {31'd0, bus_hit}, 32'd1);
      bus_addr = 12'h304; #1;
      chk("R9 data hit", {31'd0, bus_hit}, 32'd1);
      @(posedge clk); #1 bus_rd = 0;
      brd(12'h304, rv); chk("R9 data untouched", rv, 32'h000000EF);
      brd(12'h300, rv); chk("R9 cmd untouched", rv, 32'd0);

      // R10 stray acknowledge
      @(negedge clk); phy_rdata = 8'h77; phy_ack = 1;
      @(negedge clk); phy_ack = 0;
      brd(12'h304, rv); chk("R10 data after stray ack", rv, 32'h000000EF);
      brd(12'h300, rv); chk("R10 busy after stray ack", rv, 32'd0);

      // R5/R6/R4/R8 with hand-held acknowledge: read of offset 0x05
      bwr(12'h304, 32'd0);
      bwr(12'h300, 32'h00000005);
      #1;
      chk("R2 req", {31'd0, phy_req}, 32'd1);
      chk("R2 addr", {24'd0, phy_addr}, 32'h05);
      chk("R2 dir", {31'd0, phy_we}, 32'd0);
      brd(12'h300, rv); chk("R5 busy set", rv, 32'h00000205);
      bwr(12'h300, 32'h000001AA);
      #1;
      chk("R6 addr kept", {24'd0, phy_addr}, 32'h05);
      chk("R6 dir kept", {31'd0, phy_we}, 32'd0);
      brd(12'h300, rv); chk("R6 cmd word kept", rv, 32'h00000205);
      brd(12'h304, rv); chk("R4 data before ack", rv, 32'd0);
      @(negedge clk); phy_rdata = 8'h3C; phy_ack = 1;
      @(negedge clk); phy_ack = 0; #1;
      chk("R4 req dropped", {31'd0, phy_req}, 32'd0);
      brd(12'h300, rv); chk("R4 R8 cmd after ack", rv, 32'h00000005);
      brd(12'h304, rv); chk("R4 data captured", rv, 32'h0000003C);

      // R11 write ended by ack carrying junk
      bwr(12'h304, 32'h00000042);
      bwr(12'h300, 32'h00000111);
      #1;
      chk("R3 wdata", {24'd0, phy_wdata}, 32'h42);
      chk("R2 dir write", {31'd0, phy_we}, 32'd1);
      @(negedge clk); phy_rdata = 8'h99; phy_ack = 1;
      @(negedge clk); phy_ack = 0;
      brd(12'h304, rv); chk("R11 data kept", rv, 32'h00000042);
      brd(12'h300, rv); chk("R8 write dir readback", rv, 32'h00000111);

      // Sweep: write every PHY offset, then read every one back
      model_on = 1;
      for (int a = 0; a < 256; a++) begin
         exp_w = pat(a);
         bwr(12'h304, {24'hA5A5A5, pat(a)});
         bwr(12'h300, 32'h100 | 32'(a));
         #1;
         chk("R2 sweep addr", {24'd0, phy_addr}, 32'(a));
         chk("R2 sweep req", {31'd0, phy_req}, 32'd1);
         poll();
      end
      for (int a = 0; a < 256; a++) begin
         bwr(12'h304, 32'd0);
         bwr(12'h300, 32'(a));
         poll();
         brd(12'h304, rv); chk("R4 sweep readback", rv, {24'd0, pat(a)});
         brd(12'h300, rv); chk("R8 sweep cmd", rv, 32'(a));
      end

      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule